// File: doc/BRIEF.md
# Decaying Open-Bus Data Latch

This block holds the last byte seen on a floating data bus and models the way an undriven bus line loses its charge. A free-running cycle counter advances on every tick. Each of the eight bits keeps its own refresh timestamp. When a bit is read, its age is the current count minus its timestamp. A bit that is stored as 1 and has aged past the decay limit reads back as 0.

There are two kinds of write. Both load the whole byte. A plain write refreshes the timestamp of every bit written as 1. A masked write refreshes only the bits that are written as 1 and are also selected by a mask. This lets a caller drive a byte while only some of its lines are truly being driven.

The read port is combinational. The decay is applied only on the read path, so the stored byte itself never changes because of age. A restore port loads the byte, all eight timestamps and the counter in a single cycle, so that a saved state can be brought back.

Top module: `obus_decay_latch`

## Requirements
- R1: After reset, the stored byte, all eight timestamps and the cycle counter are zero, so `rdData` reads 0x00.
- R2: On each cycle where `tickEn` is 1 and `restEn` is 0, the 32-bit counter goes up by one and wraps from 0xFFFFFFFF to 0. Without a tick the counter holds its value.
- R3: A plain write (`wrEn`) stores all eight bits of `wrData`, and the stored byte is visible on `rdData` from the next cycle.
- R4: A plain write sets the timestamp of each bit written as 1 to the counter value of that cycle, taken before any tick in the same cycle. A bit written as 0 keeps its old timestamp.
- R5: A masked write (`mwrEn`, with `wrEn` 0) stores all eight bits of `mwrData`. It refreshes only the timestamps of bits that are 1 in both `mwrData` and `mwrMask`.
- R6: `rdData` bit i is 0 when the stored bit i is 0, or when the age (count minus timestamp i) is greater than 3,216,312. An age of exactly 3,216,312 still reads as 1.
- R7: The age saturates at zero. A timestamp above the current count gives an age of 0, so that bit reads as stored.
- R8: Decay never changes the stored byte. A bit that reads 0 because of age reads 1 again once its age falls back within the limit, for example when the counter wraps.
- R9: When `restEn` is 1, the byte, the eight timestamps and the counter are loaded from `restData`, `restStamps` (bit i's timestamp is at bits [32*i+31:32*i]) and `restCount`. In that cycle any tick, plain write or masked write is ignored.
- R10: If a plain write and a masked write arrive in the same cycle, the plain write wins and the masked write is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| tickEn | input | 1 | Advance the cycle counter by one |
| wrEn | input | 1 | Plain write strobe |
| wrData | input | 8 | Plain write byte |
| mwrEn | input | 1 | Masked write strobe |
| mwrData | input | 8 | Masked write byte |
| mwrMask | input | 8 | Bits allowed to refresh on a masked write |
| restEn | input | 1 | Restore strobe |
| restData | input | 8 | Byte to restore |
| restStamps | input | 256 | Eight 32-bit timestamps, bit i at [32*i+31:32*i] |
| restCount | input | 32 | Counter value to restore |
| rdData | output | 8 | Stored byte with aged bits forced to 0 (combinational) |

## Verification
A wrong timestamp or counter is invisible while the stored byte's bits are 0, or while every age is far from the limit. It shows only as a single bit of `rdData` that is wrong in the cycle in which that bit's age crosses 3,216,312. For this reason the directed cases use restore to place the counter and the timestamps right at the limit, and then tick once, so that an error in the age arithmetic shows up in the very next cycle. The cases that mix bits in one byte make sure that a refresh applied to the wrong bit is seen as a neighbouring bit that reads differently.

// File: rtl/obus_pkg.sv
package obus_pkg;
  localparam int OB_DATA_W      = 8;
  localparam int OB_CNT_W       = 32;
  localparam int OB_DECAY_LIMIT = 3216312;

  // Strobes from control to datapath
  typedef struct packed {
    logic                 restoreEn;
    logic                 tickEn;
    logic                 loadEn;
    logic [OB_DATA_W-1:0] loadVal;
    logic [OB_DATA_W-1:0] refreshSel;
  } obStrobe_t;
endpackage

// File: rtl/obus_ctl.sv
module obus_ctl
  import obus_pkg::*;
(
  input  logic                 tickEn,
  input  logic                 wrEn,
  input  logic [OB_DATA_W-1:0] wrData,
  input  logic                 mwrEn,
  input  logic [OB_DATA_W-1:0] mwrData,
  input  logic [OB_DATA_W-1:0] mwrMask,
  input  logic                 restEn,
  output obStrobe_t            strb
);
  // Restore wins over everything; a plain write wins over a masked write.
  always_comb begin
    strb           = '0;
    strb.restoreEn = restEn;
    if (!restEn) begin
      strb.tickEn = tickEn;
      if (wrEn) begin
        strb.loadEn     = 1'b1;
        strb.loadVal    = wrData;
        strb.refreshSel = wrData;
      end else if (mwrEn) begin
        strb.loadEn     = 1'b1;
        strb.loadVal    = mwrData;
        strb.refreshSel = mwrData & mwrMask;
      end
    end
  end
endmodule

// File: rtl/obus_age_cmp.sv
module obus_age_cmp #(
  parameter int          CNT_W       = 32,
  parameter int unsigned DECAY_LIMIT = 3216312
) (
  input  logic [CNT_W-1:0] nowCount,
  input  logic [CNT_W-1:0] stamp,
  output logic             stale
);
  localparam logic [CNT_W-1:0] LIMIT_V = CNT_W'(DECAY_LIMIT);

  logic [CNT_W-1:0] age;

  // The age never goes below zero.
  always_comb begin
    age   = (nowCount >= stamp) ? (nowCount - stamp) : '0;
    stale = (age > LIMIT_V);
  end
endmodule

// File: rtl/obus_dp.sv
module obus_dp
  import obus_pkg::*;
#(
  parameter int          CNT_W       = OB_CNT_W,
  parameter int unsigned DECAY_LIMIT = OB_DECAY_LIMIT
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  obStrobe_t                  strb,
  input  logic [OB_DATA_W-1:0]       restData,
  input  logic [OB_DATA_W*CNT_W-1:0] restStamps,
  input  logic [CNT_W-1:0]           restCount,
  output logic [OB_DATA_W-1:0]       rdData,
  output logic [OB_DATA_W-1:0]       latchQ,
  output logic [CNT_W-1:0]           countQ,
  output logic [OB_DATA_W*CNT_W-1:0] stampFlat
);
  logic [OB_DATA_W-1:0] staleBits;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      countQ <= '0;
      latchQ <= '0;
    end else if (strb.restoreEn) begin
      countQ <= restCount;
      latchQ <= restData;
    end else begin
      if (strb.tickEn) countQ <= countQ + 1'b1;
      if (strb.loadEn) latchQ <= strb.loadVal;
    end
  end

  for (genvar i = 0; i < OB_DATA_W; i++) begin : g_bit
    logic [CNT_W-1:0] stampQ;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)
        stampQ <= '0;
      else if (strb.restoreEn)
        stampQ <= restStamps[i*CNT_W +: CNT_W];
      else if (strb.refreshSel[i])
        stampQ <= countQ;
    end

    obus_age_cmp #(.CNT_W(CNT_W), .DECAY_LIMIT(DECAY_LIMIT)) age_i (
      .nowCount(countQ),
      .stamp   (stampQ),
      .stale   (staleBits[i])
    );

    assign stampFlat[i*CNT_W +: CNT_W] = stampQ;
    assign rdData[i] = latchQ[i] & ~staleBits[i];
  end
endmodule

// File: rtl/obus_decay_latch.sv
module obus_decay_latch
  import obus_pkg::*;
#(
  parameter int          CNT_W       = OB_CNT_W,
  parameter int unsigned DECAY_LIMIT = OB_DECAY_LIMIT
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       tickEn,
  input  logic                       wrEn,
  input  logic [OB_DATA_W-1:0]       wrData,
  input  logic                       mwrEn,
  input  logic [OB_DATA_W-1:0]       mwrData,
  input  logic [OB_DATA_W-1:0]       mwrMask,
  input  logic                       restEn,
  input  logic [OB_DATA_W-1:0]       restData,
  input  logic [OB_DATA_W*CNT_W-1:0] restStamps,
  input  logic [CNT_W-1:0]           restCount,
  output logic [OB_DATA_W-1:0]       rdData
);
  obStrobe_t                  strb;
  logic [OB_DATA_W-1:0]       latchQ;
  logic [CNT_W-1:0]           countQ;
  logic [OB_DATA_W*CNT_W-1:0] stampFlat;

  obus_ctl ctl_i (
    .tickEn (tickEn),
    .wrEn   (wrEn),
    .wrData (wrData),
    .mwrEn  (mwrEn),
    .mwrData(mwrData),
    .mwrMask(mwrMask),
    .restEn (restEn),
    .strb   (strb)
  );

  obus_dp #(.CNT_W(CNT_W), .DECAY_LIMIT(DECAY_LIMIT)) dp_i (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .restData  (restData),
    .restStamps(restStamps),
    .restCount (restCount),
    .rdData    (rdData),
    .latchQ    (latchQ),
    .countQ    (countQ),
    .stampFlat (stampFlat)
  );
endmodule

// File: rtl/obus_decay_chk.sv
module obus_decay_chk
  import obus_pkg::*;
#(
  parameter int CNT_W = OB_CNT_W
) (
  input logic                       clk,
  input logic                       rstN,
  input logic                       tickEn,
  input logic                       wrEn,
  input logic [OB_DATA_W-1:0]       wrData,
  input logic                       mwrEn,
  input logic [OB_DATA_W-1:0]       mwrData,
  input logic                       restEn,
  input logic [OB_DATA_W-1:0]       restData,
  input logic [CNT_W-1:0]           restCount,
  input logic [OB_DATA_W-1:0]       rdData,
  input logic [OB_DATA_W-1:0]       latchQ,
  input logic [CNT_W-1:0]           countQ,
  input logic [OB_DATA_W*CNT_W-1:0] stampFlat
);
  // R2
  tick_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (tickEn && !restEn) |=> countQ == CNT_W'($past(countQ) + 1'b1));

  // R2
  count_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!tickEn && !restEn) |=> $stable(countQ));

  // R3
  wr_store_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && !restEn) |=> latchQ == $past(wrData));

  // R4
  stamp_refresh_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && !restEn && wrData[0]) |=> stampFlat[CNT_W-1:0] == $past(countQ));

  // R4
  stamp_keep_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && !restEn && !wrData[0]) |=> $stable(stampFlat[CNT_W-1:0]));

  // R10
  mwr_store_chk: assert property (@(posedge clk) disable iff (!rstN)
    (mwrEn && !wrEn && !restEn) |=> latchQ == $past(mwrData));

  // R6
  read_subset_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rdData & ~latchQ) == '0);

  // R7
  sat_age_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stampFlat[CNT_W-1:0] > countQ) |-> rdData[0] == latchQ[0]);

  // R9
  restore_chk: assert property (@(posedge clk) disable iff (!rstN)
    restEn |=> (countQ == $past(restCount)) && (latchQ == $past(restData)));
endmodule

bind obus_decay_latch obus_decay_chk #(.CNT_W(CNT_W)) chk_i (
  .clk      (clk),
  .rstN     (rstN),
  .tickEn   (tickEn),
  .wrEn     (wrEn),
  .wrData   (wrData),
  .mwrEn    (mwrEn),
  .mwrData  (mwrData),
  .restEn   (restEn),
  .restData (restData),
  .restCount(restCount),
  .rdData   (rdData),
  .latchQ   (latchQ),
  .countQ   (countQ),
  .stampFlat(stampFlat)
);

// File: tb/obus_decay_latch_tb.sv
module obus_decay_latch_tb_top;
  localparam int DW  = 8;
  localparam int CW  = 32;
  localparam int LIM = 3216312;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          tickEn = 1'b0, wrEn = 1'b0, mwrEn = 1'b0, restEn = 1'b0;
  logic [DW-1:0] wrData = '0, mwrData = '0, mwrMask = '0, restData = '0;
  logic [DW*CW-1:0] restStamps = '0;
  logic [CW-1:0] restCount = '0;
  logic [DW-1:0] rdData;

  int nChecks = 0;
  int nFails  = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  obus_decay_latch dut_i (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .wrEn(wrEn), .wrData(wrData),
    .mwrEn(mwrEn), .mwrData(mwrData), .mwrMask(mwrMask), .restEn(restEn),
    .restData(restData), .restStamps(restStamps), .restCount(restCount),
    .rdData(rdData)
  );

  task automatic check(input string req, input logic [DW-1:0] got, input logic [DW-1:0] exp);
    nChecks++;
    if (got !== exp) begin
      nFails++;
      $display("FAIL %s: rdData actual 0x%02h expected 0x%02h", req, got, exp);
    end
  endtask

  // Let one rising edge pass, return at the following falling edge.
  task automatic cyc();
    @(posedge clk);
    @(negedge clk);
    tickEn = 1'b0; wrEn = 1'b0; mwrEn = 1'b0; restEn = 1'b0;
  endtask

  task automatic restoreAll(input logic [DW-1:0] v, input logic [CW-1:0] st,
                            input logic [CW-1:0] cnt);
    restEn = 1'b1; restData = v; restCount = cnt;
    for (int i = 0; i < DW; i++) restStamps[i*CW +: CW] = st;
    cyc();
  endtask

  task automatic doTick();
    tickEn = 1'b1; cyc();
  endtask

  task automatic doWrite(input logic [DW-1:0] d);
    wrEn = 1'b1; wrData = d; cyc();
  endtask

  task automatic doMaskWrite(input logic [DW-1:0] d, input logic [DW-1:0] m);
    mwrEn = 1'b1; mwrData = d; mwrMask = m; cyc();
  endtask

  task automatic testReset();
    check("R1 reset", rdData, 8'h00);
  endtask

  task automatic testWrite();
    doWrite(8'h5A);
    check("R3 plain write visible", rdData, 8'h5A);
    doWrite(8'hC3);
    check("R3 plain write replaces", rdData, 8'hC3);
  endtask

  task automatic testDecayEdge();
    restoreAll(8'hFF, '0, CW'(LIM));
    check("R6 age equal to limit still reads 1", rdData, 8'hFF);
    doTick();
    check("R6 age one past limit reads 0", rdData, 8'h00);
  endtask

  task automatic testTickHold();
    restoreAll(8'h01, '0, CW'(LIM));
    repeat (3) cyc();
    check("R2 counter holds without tick", rdData, 8'h01);
  endtask

  task automatic testPerBit();
    restEn = 1'b1; restData = 8'hA5; restCount = CW'(LIM + 1);
    for (int i = 0; i < DW; i++) restStamps[i*CW +: CW] = (i == 0) ? CW'(100) : '0;
    cyc();
    check("R6 bits age independently", rdData, 8'h01);
  endtask

  task automatic testRefreshSelect();
    restoreAll(8'h00, '0, CW'(4000000));
    doWrite(8'h0F);
    doMaskWrite(8'hFF, 8'h00);
    check("R5 mask zero refreshes nothing", rdData, 8'h0F);
    doMaskWrite(8'hFF, 8'h30);
    check("R5 masked refresh only selected ones", rdData, 8'h3F);
    doWrite(8'h00);
    doMaskWrite(8'hFF, 8'h00);
    check("R4 bits written 0 keep their stamps", rdData, 8'h3F);
  endtask

  task automatic testSaturate();
    restoreAll(8'hFF, CW'(32'hFFFF0000), CW'(10));
    check("R7 stamp above count reads as stored", rdData, 8'hFF);
  endtask

  task automatic testWrapRevive();
    restoreAll(8'h80, '0, CW'(32'hFFFFFFFF));
    check("R8 aged bit reads 0", rdData, 8'h00);
    restEn = 1'b1; restData = 8'h80; restCount = CW'(32'hFFFFFFFF);
    for (int i = 0; i < DW; i++) restStamps[i*CW +: CW] = CW'(32'hFFFFFFFF);
    cyc();
    restStamps[7*CW +: CW] = '0;
    restEn = 1'b1; cyc();
    doTick();
    check("R2 counter wraps to 0 and R8 stored bit survives", rdData, 8'h80);
  endtask

  task automatic testRestorePriority();
    restEn = 1'b1; restData = 8'hFF; restCount = CW'(LIM);
    for (int i = 0; i < DW; i++) restStamps[i*CW +: CW] = '0;
    tickEn = 1'b1; wrEn = 1'b1; wrData = 8'h00; mwrEn = 1'b1; mwrData = 8'h00; mwrMask = 8'hFF;
    cyc();
    check("R9 restore beats tick and writes", rdData, 8'hFF);
    doTick();
    check("R9 restored count used", rdData, 8'h00);
  endtask

  task automatic testWritePriority();
    restoreAll(8'h00, '0, CW'(LIM + 1));
    wrEn = 1'b1; wrData = 8'h01; mwrEn = 1'b1; mwrData = 8'h02; mwrMask = 8'hFF;
    tickEn = 1'b1;
    cyc();
    check("R10 plain write wins over masked", rdData, 8'h01);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testWrite();
    testDecayEdge();
    testTickHold();
    testPerBit();
    testRefreshSelect();
    testSaturate();
    testWrapRevive();
    testRestorePriority();
    testWritePriority();
    if (!finished) begin
      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      nChecks++;
      nFails++;
      $display("FAIL watchdog: run did not end, actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end
endmodule